// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a cycle-accurate behavioural model of a synchronous flow-through burst SRAM. The word is 32 bits wide and split into four byte lanes. Every control input is sampled on the rising clock edge. Each edge is decoded into one of four operations:

- deselect
- start a burst at the external address
- step the burst to its next address
- hold the burst at its current address

A write operation updates the internal array at the edge that samples it. A read operation presents the addressed word during the clock period that follows the edge that registered it. No further output register stage sits in the read path.

A burst can be started by either of two address strobes. The CPU strobe always starts a read, and it only counts when the primary enable is active. The cache-controller strobe starts a read or a write, as chosen by the write inputs. The two secondary enables are examined only on edges where a strobe is active. Burst addresses are generated internally. They cover four words, and the `linear_i` pin selects a linear or an interleaved order. A snooze input puts the model into a power-down state, and recovery from that state takes a fixed number of cycles.

Top module: `sync_burst_sram`

## Requirements
- R1: On an edge where `en_pri_ni` is high and `start_cc_ni` is low, the cycle is a deselect. Nothing is written, and `rdrive_o` is low for the following period. Later edges with both strobes high stay deselected until a new burst start.
- R2: On an edge with an active strobe, the start becomes a deselect when `en_sec_i` is low or `en_sec_ni` is high. On edges with no active strobe, both secondary enables have no effect.
- R3: `start_cpu_ni` has no effect while `en_pri_ni` is high, and such an edge behaves as a step or a hold. A CPU-strobe start is always a read and writes nothing. This holds even when the write inputs request a write or `start_cc_ni` is also low.
- R4: A cache-controller start (`start_cc_ni` low, `en_pri_ni` low, secondary enables active, CPU strobe inactive) accesses `addr_i`. It is a write when the lane mask of R7 is nonzero and a read otherwise.
- R5: On an edge with both strobes high and `step_ni` low, a selected burst moves to its next address. The upper address bits stay fixed. At beat n (n = 0..3, wrapping after 3), the low two bits are (start + n) mod 4 when `linear_i` is 1 and start XOR n when `linear_i` is 0.
- R6: On an edge with both strobes high and `step_ni` high, a selected burst accesses its current address again. The write inputs choose read or write on this edge.
- R7: When `wr_all_ni` is low, the lane mask is all four lanes. Otherwise, when `lane_wr_en_ni` is low, lane i (data bits 8i+7:8i) is in the mask exactly when `lane_wr_ni[i]` is low. Otherwise the mask is empty. Lanes outside the mask keep their stored bytes.
- R8: After an edge that registers a read, `rdata_o` shows the addressed word during that same period. `rdrive_o` is high whenever `out_en_ni` is low, and this follows `out_en_ni` combinationally. When `rdrive_o` is low, `rdata_o` is zero.
- R9: A write, including every beat of a burst write with its own per-beat lane mask, completes at the edge that samples it. A read at any later edge returns the new data. `rdrive_o` is low in the period after a write edge.
- R10: `asleep_o` rises at the second consecutive edge that samples `snooze_i` high. It falls at the first edge that samples `snooze_i` low. That edge and the next two edges are all deselects. Any access attempted while `snooze_i` is high is also a deselect.
- R11: After reset, `rdrive_o` and `asleep_o` are low and the model is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (8) | External word address |
| start_cpu_ni | input | 1 | CPU address strobe, active low |
| start_cc_ni | input | 1 | Cache-controller address strobe, active low |
| step_ni | input | 1 | Burst advance, active low |
| en_pri_ni | input | 1 | Primary chip enable, active low |
| en_sec_i | input | 1 | Secondary chip enable, active high |
| en_sec_ni | input | 1 | Secondary chip enable, active low |
| wr_all_ni | input | 1 | Write all lanes, active low |
| lane_wr_en_ni | input | 1 | Per-lane write enable, active low |
| lane_wr_ni | input | LANES (4) | Per-lane write selects, active low |
| out_en_ni | input | 1 | Output enable, active low, asynchronous |
| snooze_i | input | 1 | Snooze request |
| linear_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not driven |
| rdrive_o | output | 1 | Read data is driven (low models high impedance) |
| asleep_o | output | 1 | Power-down state reached |

## Verification
The embedded assertions check a set of properties on every cycle:
- a deselect or a snooze block never writes or drives;
- a CPU-strobe start never writes;
- a write leaves the bus undriven in the following period;
- a step or hold moves the burst counter by exactly one or zero;
- a wake-up stays blocked after `asleep_o` falls.

Some behaviour only the bench scenarios can show, by reading data back:
- that the burst addresses follow the linear and interleaved orders, including the wrap;
- that masked lanes keep their stored bytes;
- that ignored strobes and enables leave the stored contents unchanged;
- that recovery lasts exactly the stated number of edges.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {OP_DESEL, OP_START, OP_NEXT, OP_HOLD} op_e;

  // low address bits of burst beat n from start s
  function automatic logic [BURST_W-1:0] beat_lo(logic [BURST_W-1:0] s,
                                                 logic [BURST_W-1:0] n,
                                                 logic lin);
    return lin ? BURST_W'(s + n) : (s ^ n);
  endfunction
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
(
  input  logic start_cpu_ni,
  input  logic start_cc_ni,
  input  logic step_ni,
  input  logic en_pri_ni,
  input  logic en_sec_i,
  input  logic en_sec_ni,
  input  logic wr_req_i,
  input  logic gate_i,
  input  logic sel_i,
  output op_e  op_o,
  output logic wr_o
);
  logic cpu_act, cc_act, sec_ok;

  assign cpu_act = !start_cpu_ni && !en_pri_ni;
  assign cc_act  = !start_cc_ni;
  assign sec_ok  = en_sec_i && !en_sec_ni;

  always_comb begin
    op_o = OP_DESEL;
    wr_o = 1'b0;
    if (!gate_i) begin
      op_o = OP_DESEL;
    end else if (en_pri_ni && cc_act) begin
      op_o = OP_DESEL;
    end else if ((cpu_act || cc_act) && !sec_ok) begin
      op_o = OP_DESEL;
    end else if (cpu_act) begin
      op_o = OP_START;   // cpu start: always read
    end else if (cc_act) begin
      op_o = OP_START;
      wr_o = wr_req_i;
    end else if (!sel_i) begin
      op_o = OP_DESEL;
    end else begin
      op_o = step_ni ? OP_HOLD : OP_NEXT;
      wr_o = wr_req_i;
    end
  end
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          linear_i,
  output logic [AW-1:0] acc_addr_o
);
  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + BURST_W'(1);

  always_comb begin
    unique case (op_i)
      OP_START: acc_addr_o = addr_i;
      OP_NEXT:  acc_addr_o = {base_q[AW-1:BURST_W],
                              beat_lo(base_q[BURST_W-1:0], cnt_inc, linear_i)};
      default:  acc_addr_o = {base_q[AW-1:BURST_W],
                              beat_lo(base_q[BURST_W-1:0], cnt_q, linear_i)};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (op_i)
        OP_START: begin
          base_q <= addr_i;
          cnt_q  <= '0;
        end
        OP_NEXT: cnt_q <= cnt_inc;
        default: ;
      endcase
    end
  end

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_START |=> (base_q == $past(addr_i)) && (cnt_q == '0));
  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_NEXT |=> cnt_q == BURST_W'($past(cnt_q) + 1'b1));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> $stable(cnt_q) && $stable(base_q));
endmodule

// File: rtl/sbsram_snooze.sv
module sbsram_snooze #(
  parameter int ENTER_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic snooze_i,
  output logic gate_o,
  output logic asleep_o
);
  localparam int MAXC = (ENTER_CYC > RECOV_CYC) ? ENTER_CYC : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_RUN, S_ENTER, S_SLEEP, S_WAKE} snz_e;

  snz_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_RUN;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_RUN: if (snooze_i) begin
          st_q  <= S_ENTER;
          cnt_q <= '0;
        end
        S_ENTER: begin
          if (!snooze_i) begin
            st_q  <= S_WAKE;
            cnt_q <= '0;
          end else if (cnt_q == CW'(ENTER_CYC - 2)) begin
            st_q <= S_SLEEP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_SLEEP: if (!snooze_i) begin
          st_q  <= S_WAKE;
          cnt_q <= '0;
        end
        S_WAKE: begin
          if (snooze_i) begin
            st_q  <= S_ENTER;
            cnt_q <= '0;
          end else if (cnt_q == CW'(RECOV_CYC - 1)) begin
            st_q <= S_RUN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= S_RUN;
      endcase
    end
  end

  assign gate_o   = (st_q == S_RUN) && !snooze_i;
  assign asleep_o = (st_q == S_SLEEP);

  a_r10_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> $past(snooze_i, 1) && $past(snooze_i, 2));
  a_r10_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> !gate_o);
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int AW        = 8,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int ENTER_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    start_cpu_ni,
  input  logic                    start_cc_ni,
  input  logic                    step_ni,
  input  logic                    en_pri_ni,
  input  logic                    en_sec_i,
  input  logic                    en_sec_ni,
  input  logic                    wr_all_ni,
  input  logic                    lane_wr_en_ni,
  input  logic [LANES-1:0]        lane_wr_ni,
  input  logic                    out_en_ni,
  input  logic                    snooze_i,
  input  logic                    linear_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdrive_o,
  output logic                    asleep_o
);
  localparam int DW = LANES * LANE_W;

  logic [LANES-1:0] lane_mask, mem_we;
  logic             gate, sel_q, rd_q, is_wr;
  op_e              op;
  logic [AW-1:0]    acc_addr, raddr_q;
  logic [DW-1:0]    arr_rdata;

  always_comb begin
    if (!wr_all_ni)         lane_mask = '1;
    else if (!lane_wr_en_ni) lane_mask = ~lane_wr_ni;
    else                    lane_mask = '0;
  end

  sbsram_snooze #(.ENTER_CYC(ENTER_CYC), .RECOV_CYC(RECOV_CYC)) u_snooze (
    .clk_i, .rst_ni, .snooze_i, .gate_o(gate), .asleep_o
  );

  sbsram_decode u_decode (
    .start_cpu_ni, .start_cc_ni, .step_ni, .en_pri_ni, .en_sec_i, .en_sec_ni,
    .wr_req_i(|lane_mask), .gate_i(gate), .sel_i(sel_q), .op_o(op), .wr_o(is_wr)
  );

  sbsram_burst #(.AW(AW)) u_burst (
    .clk_i, .rst_ni, .op_i(op), .addr_i, .linear_i, .acc_addr_o(acc_addr)
  );

  assign mem_we = (op != OP_DESEL && is_wr) ? lane_mask : '0;

  sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .we_i(mem_we), .waddr_i(acc_addr), .wdata_i,
    .raddr_i(raddr_q), .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
      raddr_q <= '0;
    end else begin
      if (op == OP_DESEL)      sel_q <= 1'b0;
      else if (op == OP_START) sel_q <= 1'b1;
      rd_q    <= (op != OP_DESEL) && !is_wr;
      raddr_q <= acc_addr;
    end
  end

  // flow-through: array output straight to pins, gated by async output enable
  assign rdrive_o = rd_q && !out_en_ni;
  assign rdata_o  = rdrive_o ? arr_rdata : '0;

  a_r1_desel_nodrive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_pri_ni && !start_cc_ni) |=> !rdrive_o);
  a_r1_desel_nowrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_pri_ni && !start_cc_ni) |-> mem_we == '0);
  a_r3_cpu_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_cpu_ni && !en_pri_ni) |-> mem_we == '0);
  a_r7_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_all_ni && mem_we != '0) |-> &mem_we);
  a_r9_wr_nodrive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we != '0) |=> !rdrive_o);
  a_r10_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |-> mem_we == '0);
endmodule

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  addr_i;
  logic        start_cpu_ni, start_cc_ni, step_ni, en_pri_ni, en_sec_i, en_sec_ni;
  logic        wr_all_ni, lane_wr_en_ni, out_en_ni, snooze_i, linear_i;
  logic [3:0]  lane_wr_ni;
  logic [31:0] wdata_i, rdata_o;
  logic        rdrive_o, asleep_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] ref_mem [256];

  always #10 clk_i = ~clk_i;

  sync_burst_sram dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic idle();
    en_pri_ni = 1; start_cc_ni = 0; start_cpu_ni = 1; step_ni = 1;
    wr_all_ni = 1; lane_wr_en_ni = 1; lane_wr_ni = '1;
    en_sec_i = 1; en_sec_ni = 0; out_en_ni = 0; wdata_i = '0; addr_i = '0;
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] m);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] baddr(logic [7:0] b, int n, logic lin);
    logic [1:0] nn = 2'(n);
    return {b[7:2], lin ? 2'(b[1:0] + nn) : (b[1:0] ^ nn)};
  endfunction

  task automatic cc_start(logic [7:0] a);
    en_pri_ni = 0; start_cc_ni = 0; start_cpu_ni = 1; addr_i = a;
  endtask

  task automatic wr_full(logic [7:0] a, logic [31:0] d, string tag);
    idle(); cc_start(a); wr_all_ni = 0; wdata_i = d;
    tick();
    chk({tag, " write nodrive"}, {31'b0, rdrive_o}, 0);
    ref_mem[a] = d;
    idle();
  endtask

  task automatic rd_chk(logic [7:0] a, string tag);
    idle(); cc_start(a);
    tick();
    chk({tag, " drive"}, {31'b0, rdrive_o}, 1);
    chk({tag, " data"}, rdata_o, ref_mem[a]);
    idle();
  endtask

  task automatic cont(logic step_n, string tag, logic [7:0] exp_a);
    start_cc_ni = 1; start_cpu_ni = 1; step_ni = step_n;
    tick();
    chk({tag, " drive"}, {31'b0, rdrive_o}, 1);
    chk({tag, " data"}, rdata_o, ref_mem[exp_a]);
  endtask

  initial begin
    idle(); snooze_i = 0; linear_i = 1; rst_ni = 0;
    repeat (3) @(posedge clk_i);
    #2;
    // R11 reset state
    chk("R11 rdrive", {31'b0, rdrive_o}, 0);
    chk("R11 asleep", {31'b0, asleep_o}, 0);
    chk("R11 rdata", rdata_o, 0);
    rst_ni = 1;
    tick();
    chk("R11 deselected", {31'b0, rdrive_o}, 0);

    // R4 full writes, R8/R9 reads
    for (int a = 0; a < 96; a++) wr_full(8'(a), 32'h0101_0101 * a ^ 32'hA5C3_0000, "R4");
    for (int a = 0; a < 96; a += 7) rd_chk(8'(a), "R8 R9 readback");

    // R8 output enable high then low within one period
    idle(); cc_start(8'd10); out_en_ni = 1;
    tick();
    chk("R8 oe high drive", {31'b0, rdrive_o}, 0);
    chk("R8 oe high data", rdata_o, 0);
    out_en_ni = 0; #1;
    chk("R8 oe async drive", {31'b0, rdrive_o}, 1);
    chk("R8 oe async data", rdata_o, ref_mem[10]);
    idle();

    // R7 lane mask sweep
    for (int m = 0; m < 16; m++) begin
      logic [7:0] a = 8'(32 + m);
      idle(); cc_start(a); lane_wr_en_ni = 0; lane_wr_ni = ~4'(m);
      wdata_i = 32'hDEAD_BEEF ^ (32'h1111_1111 * m);
      tick();
      ref_mem[a] = merge(ref_mem[a], wdata_i, 4'(m));
      idle();
      rd_chk(a, "R7 lane mask");
    end
    // R7 global write overrides lane selects
    idle(); cc_start(8'd50); wr_all_ni = 0; lane_wr_en_ni = 0; lane_wr_ni = 4'b1110;
    wdata_i = 32'h1234_5678; tick(); ref_mem[50] = wdata_i; idle();
    rd_chk(8'd50, "R7 global");
    // R7 lane enable high: read, nothing written
    idle(); cc_start(8'd51); lane_wr_ni = 4'b0000; wdata_i = 32'hFFFF_FFFF;
    tick();
    chk("R7 no-enable is read", rdata_o, ref_mem[51]);
    idle();

    // R5 burst orders for every start offset, with wrap
    for (int lin = 0; lin < 2; lin++)
      for (int s = 0; s < 4; s++) begin
        logic [7:0] b = 8'(64 + s);
        idle(); linear_i = 1'(lin); cc_start(b);
        tick();
        chk("R5 beat0", rdata_o, ref_mem[b]);
        for (int n = 1; n <= 4; n++) cont(1'b0, "R5 beat", baddr(b, n, 1'(lin)));
        linear_i = 1;
      end

    // R6 suspend, R2 enables ignored mid-burst
    idle(); cc_start(8'd69); tick();
    cont(1'b1, "R6 hold", 8'd69);
    cont(1'b1, "R6 hold again", 8'd69);
    en_sec_i = 0; en_sec_ni = 1;
    cont(1'b0, "R2 ignored on step", 8'd70);
    en_sec_i = 1; en_sec_ni = 0;

    // R9 burst write with per-beat masks
    idle(); cc_start(8'd89); wr_all_ni = 0; wdata_i = 32'hA0A0_A0A0;
    tick(); ref_mem[89] = wdata_i;
    start_cc_ni = 1; step_ni = 0; wr_all_ni = 1; lane_wr_en_ni = 0;
    lane_wr_ni = 4'b1100; wdata_i = 32'hB1B1_B1B1;
    tick(); ref_mem[90] = merge(ref_mem[90], wdata_i, 4'b0011);
    lane_wr_ni = 4'b0111; wdata_i = 32'hC2C2_C2C2;
    tick(); ref_mem[91] = merge(ref_mem[91], wdata_i, 4'b1000);
    chk("R9 burst wr nodrive", {31'b0, rdrive_o}, 0);
    lane_wr_ni = 4'b1111;
    tick();
    chk("R9 empty mask is read", rdata_o, ref_mem[88]);
    for (int a = 88; a < 92; a++) rd_chk(8'(a), "R9 burst write");

    // R3 cpu strobe ignored when primary enable high: acts as step
    idle(); cc_start(8'd64); tick();
    start_cc_ni = 1; start_cpu_ni = 0; en_pri_ni = 1; step_ni = 0;
    tick();
    chk("R3 cpu masked step", rdata_o, ref_mem[65]);
    // cpu start is read even with writes requested and cc strobe low
    idle(); en_pri_ni = 0; start_cpu_ni = 0; start_cc_ni = 1; addr_i = 8'd70;
    wr_all_ni = 0; wdata_i = 32'h0BAD_0BAD;
    tick();
    chk("R3 cpu start read", rdata_o, ref_mem[70]);
    idle(); en_pri_ni = 0; start_cpu_ni = 0; start_cc_ni = 0; addr_i = 8'd71;
    wr_all_ni = 0; wdata_i = 32'h0BAD_0BAD;
    tick();
    chk("R3 cpu wins over cc", rdata_o, ref_mem[71]);
    idle();
    rd_chk(8'd70, "R3 no write");
    rd_chk(8'd71, "R3 no write");

    // R1 deselect by primary enable with cc strobe
    idle(); en_pri_ni = 1; start_cc_ni = 0; addr_i = 8'd5; wr_all_ni = 0;
    wdata_i = 32'hFFFF_0000;
    tick();
    chk("R1 desel nodrive", {31'b0, rdrive_o}, 0);
    start_cc_ni = 1; wr_all_ni = 1; step_ni = 0;
    tick();
    chk("R1 stays deselected", {31'b0, rdrive_o}, 0);
    rd_chk(8'd5, "R1 no write");

    // R2 secondary enables at a strobe
    idle(); cc_start(8'd6); en_sec_i = 0; wr_all_ni = 0; wdata_i = 32'h7777_7777;
    tick();
    chk("R2 sec low desel", {31'b0, rdrive_o}, 0);
    idle(); cc_start(8'd6); en_sec_ni = 1;
    tick();
    chk("R2 sec_n high desel", {31'b0, rdrive_o}, 0);
    rd_chk(8'd6, "R2 no write");

    // R10 snooze entry, sleep, recovery
    idle(); snooze_i = 1; cc_start(8'd7); wr_all_ni = 0; wdata_i = 32'h5555_AAAA;
    tick();
    chk("R10 asleep after 1", {31'b0, asleep_o}, 0);
    tick();
    chk("R10 asleep after 2", {31'b0, asleep_o}, 1);
    tick();
    chk("R10 still asleep", {31'b0, asleep_o}, 1);
    snooze_i = 0;
    tick();
    chk("R10 woken", {31'b0, asleep_o}, 0);
    tick();
    chk("R10 recov1 nodrive", {31'b0, rdrive_o}, 0);
    tick();
    chk("R10 recov2 nodrive", {31'b0, rdrive_o}, 0);
    rd_chk(8'd7, "R10 no write during snooze");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule